// File: doc/BRIEF.md
# Fault Event Counter with Supply-Cycle Latch

This block watches how each power-switch pulse of a constant-off-time current-mode controller comes to an end and keeps a running score of abnormal endings. A pulse cut short by the maximum on-time timer or by the overcurrent comparator raises the score by one. A pulse ended normally by the peak-current comparator lowers it by one. Any other ending, such as a dimming cut-off or a disable, leaves it alone. The score never goes below zero. When it reaches the trip limit, the block latches off and blocks the gate drive in that same cycle.

The pulse generator marks the start of every switching cycle with `cycle_start`. When the pulse ends it sends one strobe with a two-bit reason code. Only the first ending strobe after a cycle start can move the score, so a cycle yields at most one step up or down. Once latched, the block holds its score and its latch until the supply supervisor reports a full supply cycle on `supply_restart`. That input clears both the score and the latch.

Top module: `pulse_fault_guard`

## Requirements
- R1: After reset, `fault_count` is 0, `latched_off` is 0 and `drive_out` equals `drive_req`.
- R2: An accepted ending with code 2'b11 (maximum on time) raises `fault_count` by 1 at the next clock edge.
- R3: An accepted ending with code 2'b10 (overcurrent) raises `fault_count` by 1 at the next clock edge.
- R4: An accepted ending with code 2'b01 (normal current-limit) lowers `fault_count` by 1 at the next clock edge.
- R5: An accepted code 2'b01 ending while `fault_count` is 0 leaves it at 0. A later up event counts from 0.
- R6: An accepted ending with code 2'b00 (other reason) leaves `fault_count` unchanged.
- R7: An ending strobe is accepted only if `cycle_start` was seen in an earlier cycle, or in the same cycle, with no accepted strobe since. A second strobe in the same switching cycle, or a strobe with no cycle start, changes nothing. The score changes by at most 1 per clock.
- R8: The up event that brings `fault_count` to LIMIT (default 8) forces `drive_out` low in the same cycle. At the following edge `latched_off` rises, and `drive_out` stays low for as long as it is set.
- R9: While `latched_off` is 1, no ending strobe changes `fault_count`.
- R10: A `supply_restart` pulse clears `fault_count` to 0, clears `latched_off` and drops any pending cycle start at the next edge. Only this input and reset clear `latched_off`.
- R11: Over an interleaved run of up and down events, `fault_count` equals the number of ups minus the number of downs, with each down at 0 dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| supply_restart | input | 1 | One-cycle pulse after the supply fell below its off level and rose above its on level |
| cycle_start | input | 1 | Marks the start of a switching cycle (drive pulse begins) |
| end_vld | input | 1 | Strobe: the current drive pulse has ended |
| end_code | input | 2 | Reason for the ending: 00 other, 01 current limit, 10 overcurrent, 11 maximum on time |
| drive_req | input | 1 | Gate drive request from the pulse generator |
| drive_out | output | 1 | Gate drive after fault gating |
| fault_count | output | 4 | Present fault score (width clog2(LIMIT+1)) |
| latched_off | output | 1 | Latched-off flag |

## Verification
The score is driven with four input patterns. Single endings of each reason code separate the two up sources from the down source and from the neutral code. Repeated current-limit endings at zero show whether the floor holds. Doubled strobes within one cycle, and strobes with no cycle start, show whether more than one step per cycle can leak through. A climb to the limit, followed by endings while latched and then a supply restart, separates the same-cycle drive cutoff from the registered latch and shows that only the restart releases it.

// File: rtl/fcl_pkg.sv
package fcl_pkg;

  typedef enum logic [1:0] {
    END_OTHER = 2'b00,
    END_ILIM  = 2'b01,
    END_OVRC  = 2'b10,
    END_TMAX  = 2'b11
  } end_code_e;

  typedef enum logic [1:0] {
    STEP_NONE = 2'b00,
    STEP_UP   = 2'b01,
    STEP_DOWN = 2'b10
  } step_e;

endpackage

// File: rtl/fcl_rst_sync.sv
module fcl_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/fcl_cycle_gate.sv
module fcl_cycle_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic cycle_start,
  input  logic end_vld,
  output logic accept
);
  logic armed_q;
  logic armed_d;
  logic armed_en;
  logic eff_armed;

  always_comb begin
    eff_armed = armed_q | cycle_start;
    accept    = end_vld & eff_armed & ~restart;
    armed_en  = restart | accept | cycle_start;
    if (restart)     armed_d = 1'b0;
    else if (accept) armed_d = 1'b0;
    else             armed_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        armed_q <= 1'b0;
    else if (armed_en) armed_q <= armed_d;
  end

  // R7: one accepted ending per cycle start
  p_single_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (!accept || cycle_start));

  // R10: a restart drops any pending cycle start
  p_restart_disarms_r10: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (!end_vld || cycle_start || !accept));
endmodule

// File: rtl/fcl_step_decode.sv
module fcl_step_decode
  import fcl_pkg::*;
(
  input  logic       accept,
  input  logic       frozen,
  input  logic [1:0] code,
  output step_e      step
);
  end_code_e code_e;

  always_comb begin
    code_e = end_code_e'(code);
    step   = STEP_NONE;
    if (accept && !frozen) begin
      unique case (code_e)
        END_TMAX:  step = STEP_UP;
        END_OVRC:  step = STEP_UP;
        END_ILIM:  step = STEP_DOWN;
        END_OTHER: step = STEP_NONE;
        default:   step = STEP_NONE;
      endcase
    end
  end
endmodule

// File: rtl/fcl_updown.sv
module fcl_updown
  import fcl_pkg::*;
#(
  parameter int LIMIT = 8,
  localparam int CW = $clog2(LIMIT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  step_e         step,
  input  logic          frozen,
  output logic [CW-1:0] count,
  output logic          trip_now
);
  localparam logic [CW-1:0] TOP    = CW'(LIMIT);
  localparam logic [CW-1:0] BELOW  = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (restart) begin
      cnt_d  = '0;
      cnt_en = 1'b1;
    end else begin
      unique case (step)
        STEP_UP: begin
          if (cnt_q != TOP) begin
            cnt_d  = cnt_q + 1'b1;
            cnt_en = 1'b1;
          end
        end
        STEP_DOWN: begin
          if (cnt_q != '0) begin
            cnt_d  = cnt_q - 1'b1;
            cnt_en = 1'b1;
          end
        end
        default: begin
          cnt_d  = cnt_q;
          cnt_en = 1'b0;
        end
      endcase
    end
    trip_now = !restart && (step == STEP_UP) && (cnt_q == BELOW);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count = cnt_q;

  // R5: a down request at zero keeps the floor
  p_floor_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && step == STEP_DOWN && !restart) |=> (cnt_q == '0));

  // R7: at most one step per clock
  p_one_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !restart |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1
                  || cnt_q == $past(cnt_q) - 1'b1));

  // R9: latched state freezes the score
  p_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && !restart) |=> $stable(cnt_q));

  // R10: restart empties the score
  p_restart_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == '0));
endmodule

// File: rtl/fcl_trip_latch.sv
module fcl_trip_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic trip_now,
  output logic latched
);
  logic lat_q;
  logic lat_d;
  logic lat_en;

  always_comb begin
    lat_en = restart | trip_now;
    lat_d  = !restart;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lat_q <= 1'b0;
    else if (lat_en) lat_q <= lat_d;
  end

  assign latched = lat_q;

  // R8: once set, the latch stays set until a restart
  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_q && !restart) |=> lat_q);

  // R10: restart releases the latch
  p_restart_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !lat_q);
endmodule

// File: rtl/pulse_fault_guard.sv
module pulse_fault_guard
  import fcl_pkg::*;
#(
  parameter int LIMIT = 8,
  localparam int CW = $clog2(LIMIT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          supply_restart,
  input  logic          cycle_start,
  input  logic          end_vld,
  input  logic [1:0]    end_code,
  input  logic          drive_req,
  output logic          drive_out,
  output logic [CW-1:0] fault_count,
  output logic          latched_off
);
  logic  rst_sync_n;
  logic  accept;
  logic  trip_now;
  logic  latched;
  step_e step;

  fcl_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  fcl_cycle_gate u_gate (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .restart     (supply_restart),
    .cycle_start (cycle_start),
    .end_vld     (end_vld),
    .accept      (accept)
  );

  fcl_step_decode u_decode (
    .accept (accept),
    .frozen (latched),
    .code   (end_code),
    .step   (step)
  );

  fcl_updown #(.LIMIT(LIMIT)) u_count (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .restart  (supply_restart),
    .step     (step),
    .frozen   (latched),
    .count    (fault_count),
    .trip_now (trip_now)
  );

  fcl_trip_latch u_latch (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .restart  (supply_restart),
    .trip_now (trip_now),
    .latched  (latched)
  );

  assign latched_off = latched;
  assign drive_out   = drive_req & ~latched & ~trip_now;

  // R8: reaching the limit means latched
  p_limit_latched_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (fault_count == CW'(LIMIT)) |-> latched_off);

  // R8: no drive while latched
  p_drive_low_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    latched_off |-> !drive_out);
endmodule

// File: tb/pulse_fault_guard_bench.sv
module pulse_fault_guard_bench;
  localparam int LIMIT = 8;
  localparam int CW = $clog2(LIMIT + 1);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          supply_restart;
  logic          cycle_start;
  logic          end_vld;
  logic [1:0]    end_code;
  logic          drive_req;
  logic          drive_out;
  logic [CW-1:0] fault_count;
  logic          latched_off;

  int checks = 0;
  int fails  = 0;

  typedef struct {
    logic [CW-1:0] cnt;
    logic          lat;
    string         req;
  } exp_t;
  exp_t sbq[$];

  int m_cnt;
  bit m_lat;
  bit m_armed;

  always #2.5 clk = ~clk;

  pulse_fault_guard #(.LIMIT(LIMIT)) u_pulse_fault_guard (
    .clk            (clk),
    .rst_n          (rst_n),
    .supply_restart (supply_restart),
    .cycle_start    (cycle_start),
    .end_vld        (end_vld),
    .end_code       (end_code),
    .drive_req      (drive_req),
    .drive_out      (drive_out),
    .fault_count    (fault_count),
    .latched_off    (latched_off)
  );

  task automatic check_bit(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s drive_out actual=%b expected=%b", req, act, exp);
    end
  endtask

  // monitor: compares registered outputs at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      while (sbq.size() > 0) begin
        exp_t e;
        e = sbq.pop_front();
        checks++;
        if (fault_count !== e.cnt || latched_off !== e.lat) begin
          fails++;
          $display("FAIL %s count/latched actual=%0d/%b expected=%0d/%b",
                   e.req, fault_count, latched_off, e.cnt, e.lat);
        end
      end
    end
  end

  // driver: one clock of stimulus, model update, expected pushed
  task automatic apply(input bit st, input bit vld, input logic [1:0] code,
                       input bit rs, input string req);
    bit acc;
    bit up;
    bit dn;
    bit trip;
    cycle_start    = st;
    end_vld        = vld;
    end_code       = code;
    supply_restart = rs;
    acc  = vld && (m_armed || st) && !rs;
    up   = acc && !m_lat && (code == 2'b11 || code == 2'b10);
    dn   = acc && !m_lat && (code == 2'b01);
    trip = up && (m_cnt == LIMIT - 1);
    #1;
    check_bit(req, drive_out, !m_lat && !trip);
    @(posedge clk);
    #1;
    cycle_start = 0; end_vld = 0; end_code = 2'b00; supply_restart = 0;
    if (rs) begin
      m_cnt = 0; m_lat = 0; m_armed = 0;
    end else begin
      if (up && m_cnt < LIMIT) m_cnt++;
      if (dn && m_cnt > 0) m_cnt--;
      if (trip) m_lat = 1;
      if (acc) m_armed = 0;
      else if (st) m_armed = 1;
    end
    sbq.push_back('{cnt: CW'(m_cnt), lat: m_lat, req: req});
  endtask

  task automatic pulse(input logic [1:0] code, input string req);
    apply(1, 1, code, 0, req);
  endtask

  task automatic run_all();
    rst_n = 0; supply_restart = 0; cycle_start = 0; end_vld = 0;
    end_code = 2'b00; drive_req = 1;
    m_cnt = 0; m_lat = 0; m_armed = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    apply(0, 0, 2'b00, 0, "R1");
    // R2, R3, R4
    pulse(2'b11, "R2");
    pulse(2'b10, "R3");
    pulse(2'b01, "R4");
    pulse(2'b01, "R4");
    // R5: floor at zero, then up counts from zero
    pulse(2'b01, "R5");
    pulse(2'b01, "R5");
    pulse(2'b11, "R5");
    // R6: other reason
    pulse(2'b00, "R6");
    // R7: second strobe in same cycle ignored
    pulse(2'b11, "R7");
    apply(0, 1, 2'b11, 0, "R7");
    apply(0, 1, 2'b01, 0, "R7");
    // R7: start then ending in a later clock
    apply(1, 0, 2'b00, 0, "R7");
    apply(0, 0, 2'b00, 0, "R7");
    apply(0, 1, 2'b01, 0, "R7");
    // R11: interleaved
    pulse(2'b11, "R11");
    pulse(2'b01, "R11");
    pulse(2'b10, "R11");
    pulse(2'b10, "R11");
    pulse(2'b01, "R11");
    pulse(2'b11, "R11");
    // R8: climb to the limit
    for (int i = 0; i < LIMIT; i++) pulse(2'b10, "R8");
    // R9: endings while latched change nothing
    pulse(2'b01, "R9");
    pulse(2'b01, "R9");
    pulse(2'b11, "R9");
    // R10: supply restart clears everything
    apply(0, 0, 2'b00, 1, "R10");
    apply(0, 0, 2'b00, 0, "R10");
    apply(1, 0, 2'b00, 0, "R10");
    apply(0, 0, 2'b00, 1, "R10");
    apply(0, 1, 2'b11, 0, "R10");
    pulse(2'b11, "R10");
    repeat (3) @(posedge clk);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    @(negedge clk);
    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule